// File: doc/BRIEF.md
# DDR Command Decoder with Bank Tracker

This block sits behind the registered command pins of a DDR SDRAM interface. On every rising clock edge it samples chip select, the three strobes (row, column, write), clock enable, the two bank-select bits and the multiplexed address. It turns that pin pattern into a one-hot command code and presents the target bank, the row or compacted column address and an auto-precharge flag. All of these are registered, so they appear one clock after sampling.

Alongside decoding, the block keeps a model of the memory's state. For each of four banks it records whether the bank is open and which row it holds. It tracks the power state implied by clock-enable transitions and a short lockout that follows a mode-register write. A command that the current state forbids raises an illegal flag and leaves every bank untouched. A monitor, a protocol checker or a controller model can use this to follow what the memory should be doing. Data capture and analog timing are outside the block.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: After reset, `cmd_o` is the no-op code (bit 0), `illegal_o` and `auto_pre_o` are 0, `bank_open_o` is 0 and `pwr_o` is 0 (powered up).
- R2: With `cs_n` low and clock enable high in this and the previous cycle, the pattern {`ras_n`,`cas_n`,`we_n`} selects the command: 011 activate (bit 1), 101 read (bit 2), 100 write (bit 3), 010 precharge (bit 4), 001 refresh (bit 5), 000 mode set (bit 6), 110 burst stop (bit 7), 111 no-op (bit 0). `cmd_o` always has exactly one bit set and appears one clock after sampling.
- R3: With `cs_n` sampled high, the command is a no-op whatever the strobes, and no bank changes state.
- R4: The bank index is 0 for `ba`=00, 1 for `ba`=10 (bit 1 high), 2 for `ba`=01 (bit 0 high) and 3 for `ba`=11. It is reported on `bank_o`. A legal activate opens that bank and stores `addr` as its row in `open_rows_o[13*index +: 13]`.
- R5: A legal precharge with `addr[10]` low closes only the addressed bank. With `addr[10]` high it closes all banks, whatever `ba` holds.
- R6: On read and write, `addr_o` carries the column {`addr[11]`,`addr[9:0]`} zero-extended to 13 bits. `auto_pre_o` equals `addr[10]`, and a legal access with it set closes the bank. For every other command `addr_o` equals `addr` and `auto_pre_o` is 0.
- R7: A read or write to a closed bank, or an activate to an open bank, sets `illegal_o` and changes no bank state or stored row.
- R8: A mode set or refresh while any bank is open sets `illegal_o`.
- R9: In the 2 cycles after a legal mode set, any command other than no-op sets `illegal_o` and is ignored. In the third cycle, commands are accepted again.
- R10: Clock enable falling with all banks closed enters state 1 (precharge power-down), or state 3 (self refresh) when the sampled pins encode refresh. With any bank open it enters state 2 (active power-down). The first cycle with clock enable high again returns to state 0. In every cycle where clock enable is low now or was low one cycle earlier, `cmd_o` is no-op and no bank changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select bits |
| addr | input | 13 | Multiplexed address |
| cmd_o | output | 8 | One-hot command code |
| bank_o | output | 2 | Target bank index |
| addr_o | output | 13 | Row, column or operand address |
| auto_pre_o | output | 1 | Auto-precharge on read or write |
| illegal_o | output | 1 | Command not allowed in current state |
| bank_open_o | output | 4 | Open flag per bank index |
| open_rows_o | output | 52 | Stored row per bank, 13 bits each |
| pwr_o | output | 2 | Power state 0..3 |

## Verification
The bench goes after the swapped bank-select order: a design that used `ba` directly as the index would open bank 2 where bank 1 was meant. It precharges all banks while `ba` points at one of them, which catches a design that ignored `addr[10]`. It repeats an activate to an already open bank and checks that the stored row keeps its old value. It issues commands in both lockout cycles after a mode set and again in the cycle after that, to catch a window that is off by one. Finally, it walks through all three power-down entries and their exits, giving the pins an activate pattern while the clock enable is low, so that a design still decoding then would be caught opening a bank.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;
    typedef enum logic [2:0] {
        C_NOP = 3'd0,
        C_ACT = 3'd1,
        C_RD  = 3'd2,
        C_WR  = 3'd3,
        C_PRE = 3'd4,
        C_REF = 3'd5,
        C_MRS = 3'd6,
        C_BST = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        P_ON    = 2'd0,
        P_PREPD = 2'd1,
        P_ACTPD = 2'd2,
        P_SELF  = 2'd3
    } pwr_e;

    localparam int CMD_W = 8;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = C_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = C_ACT;
                3'b101:  cmd = C_RD;
                3'b100:  cmd = C_WR;
                3'b010:  cmd = C_PRE;
                3'b001:  cmd = C_REF;
                3'b000:  cmd = C_MRS;
                3'b110:  cmd = C_BST;
                default: cmd = C_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_bank_file.sv
module ddr_bank_file #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS-1:0]       open_en,
    input  logic [NUM_BANKS-1:0]       close_en,
    input  logic [ROW_W-1:0]           row_in,
    output logic [NUM_BANKS-1:0]       open_o,
    output logic [NUM_BANKS*ROW_W-1:0] rows_o
);
    logic [NUM_BANKS-1:0]       open_d, open_q;
    logic [NUM_BANKS*ROW_W-1:0] rows_d, rows_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_comb begin
            open_d[g] = open_q[g];
            rows_d[g*ROW_W +: ROW_W] = rows_q[g*ROW_W +: ROW_W];
            if (open_en[g]) begin
                open_d[g] = 1'b1;
                rows_d[g*ROW_W +: ROW_W] = row_in;
            end else if (close_en[g]) begin
                open_d[g] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= '0;
            rows_q <= '0;
        end else begin
            open_q <= open_d;
            rows_q <= rows_d;
        end
    end

    assign open_o = open_q;
    assign rows_o = rows_q;

    // R7: the controller logic must never ask to open a bank that is already open
    a_r7_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (open_en & open_q) == '0);
endmodule

// File: rtl/ddr_pwr_track.sv
module ddr_pwr_track
    import ddr_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic all_idle,
    input  logic is_ref,
    output pwr_e pwr_o,
    output logic cmd_en_o
);
    typedef struct packed {
        logic cke;
        pwr_e pwr;
    } pst_t;

    pst_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cke = cke;
        if (st_q.cke && !cke) begin
            if (!all_idle)   st_d.pwr = P_ACTPD;
            else if (is_ref) st_d.pwr = P_SELF;
            else             st_d.pwr = P_PREPD;
        end else if (!st_q.cke && cke) begin
            st_d.pwr = P_ON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cke: 1'b1, pwr: P_ON};
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_o    = st_q.pwr;
    assign cmd_en_o = st_q.cke && cke;

    // R10: a clock-enable low-to-high transition always returns to powered-up
    a_r10_exit_to_on: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.cke && cke) |=> (pwr_o == P_ON));
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int MRS_GAP   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [CMD_W-1:0]           cmd_o,
    output logic [$clog2(NUM_BANKS)-1:0] bank_o,
    output logic [ROW_W-1:0]           addr_o,
    output logic                       auto_pre_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows_o,
    output logic [1:0]                 pwr_o
);
    localparam int BA_W   = $clog2(NUM_BANKS);
    localparam int LOCK_W = $clog2(MRS_GAP + 1);
    localparam int AP_BIT = 10;
    localparam int COL_W  = 11;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [BA_W-1:0]  bank;
        logic [ROW_W-1:0] addr;
        logic             auto_pre;
        logic             illegal;
        logic [LOCK_W-1:0] lock;
    } out_t;

    out_t o_d, o_q;

    cmd_e                 dec_cmd, cmd_eff;
    pwr_e                 pwr;
    logic                 cmd_en;
    logic [BA_W-1:0]      bidx;
    logic [NUM_BANKS-1:0] open_v, open_en, close_en;
    logic                 any_open, is_rw, bad;
    logic [COL_W-1:0]     col;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (dec_cmd)
    );

    ddr_pwr_track u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .all_idle (!any_open),
        .is_ref   (dec_cmd == C_REF),
        .pwr_o    (pwr),
        .cmd_en_o (cmd_en)
    );

    ddr_bank_file #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (open_en),
        .close_en (close_en),
        .row_in   (addr),
        .open_o   (open_v),
        .rows_o   (open_rows_o)
    );

    // bank index takes the select bits in reverse order
    for (genvar g = 0; g < BA_W; g++) begin : g_bidx
        assign bidx[g] = ba[BA_W-1-g];
    end

    always_comb begin
        cmd_eff  = cmd_en ? dec_cmd : C_NOP;
        any_open = |open_v;
        is_rw    = (cmd_eff == C_RD) || (cmd_eff == C_WR);
        col      = {addr[11], addr[9:0]};

        bad = 1'b0;
        if (cmd_eff != C_NOP) begin
            if (o_q.lock != '0)                                      bad = 1'b1;
            if (is_rw && !open_v[bidx])                              bad = 1'b1;
            if ((cmd_eff == C_ACT) && open_v[bidx])                  bad = 1'b1;
            if (((cmd_eff == C_MRS) || (cmd_eff == C_REF)) && any_open) bad = 1'b1;
        end

        open_en  = '0;
        close_en = '0;
        if (!bad) begin
            if (cmd_eff == C_ACT) open_en[bidx] = 1'b1;
            if (cmd_eff == C_PRE) begin
                if (addr[AP_BIT]) close_en = '1;
                else              close_en[bidx] = 1'b1;
            end
            if (is_rw && addr[AP_BIT]) close_en[bidx] = 1'b1;
        end

        o_d          = o_q;
        o_d.cmd      = '0;
        o_d.cmd[cmd_eff] = 1'b1;
        o_d.bank     = bidx;
        o_d.addr     = is_rw ? ROW_W'(col) : addr;
        o_d.auto_pre = is_rw && addr[AP_BIT];
        o_d.illegal  = bad;
        if ((cmd_eff == C_MRS) && !bad) o_d.lock = LOCK_W'(MRS_GAP);
        else if (o_q.lock != '0)        o_d.lock = o_q.lock - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{cmd: CMD_W'(1), default: '0};
        end else begin
            o_q <= o_d;
        end
    end

    assign cmd_o       = o_q.cmd;
    assign bank_o      = o_q.bank;
    assign addr_o      = o_q.addr;
    assign auto_pre_o  = o_q.auto_pre;
    assign illegal_o   = o_q.illegal;
    assign bank_open_o = open_v;
    assign pwr_o       = pwr;

    a_r2_onehot_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_o) == 1);
    a_r7_illegal_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(bank_open_o));
    a_r8_mrs_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_MRS] && !illegal_o) |-> (bank_open_o == '0));
    a_r6_autopre_rw_only: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre_o |-> (cmd_o[C_RD] || cmd_o[C_WR]));
    a_r9_lockout_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o[C_MRS] && !illegal_o) |=> (illegal_o || cmd_o[C_NOP]));
    a_r10_quiet_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_o != 2'd0) |-> cmd_o[C_NOP]);
endmodule

// File: tb/ddr_cmd_tracker_tb.sv
module ddr_cmd_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = 2'b00;
    logic [12:0] addr = '0;
    logic [7:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] addr_o;
    logic        auto_pre_o, illegal_o;
    logic [3:0]  bank_open_o;
    logic [51:0] open_rows_o;
    logic [1:0]  pwr_o;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ddr_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
        .bank_o(bank_o), .addr_o(addr_o), .auto_pre_o(auto_pre_o),
        .illegal_o(illegal_o), .bank_open_o(bank_open_o),
        .open_rows_o(open_rows_o), .pwr_o(pwr_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic k, input logic c, input logic r, input logic ca,
                         input logic w, input logic [1:0] b, input logic [12:0] a);
        @(negedge clk);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                       drive(1, 0, 1, 1, 1, 2'b00, 13'h0); endtask
    task automatic act(input logic [1:0] b, input logic [12:0] a); drive(1, 0, 0, 1, 1, b, a); endtask
    task automatic rd (input logic [1:0] b, input logic [12:0] a); drive(1, 0, 1, 0, 1, b, a); endtask
    task automatic wr (input logic [1:0] b, input logic [12:0] a); drive(1, 0, 1, 0, 0, b, a); endtask
    task automatic pre(input logic [1:0] b, input logic [12:0] a); drive(1, 0, 0, 1, 0, b, a); endtask
    task automatic refc();                      drive(1, 0, 0, 0, 1, 2'b00, 13'h0); endtask
    task automatic mrs(input logic [12:0] a);   drive(1, 0, 0, 0, 0, 2'b00, a); endtask

    task automatic t_reset();
        chk("R1 cmd", cmd_o, 8'h01);
        chk("R1 illegal", illegal_o, 0);
        chk("R1 auto_pre", auto_pre_o, 0);
        chk("R1 open", bank_open_o, 0);
        chk("R1 pwr", pwr_o, 0);
    endtask

    task automatic t_cs_mask();
        drive(1, 1, 0, 1, 1, 2'b00, 13'h0123);
        chk("R3 cmd nop", cmd_o, 8'h01);
        chk("R3 no open", bank_open_o, 0);
    endtask

    task automatic t_activate();
        act(2'b10, 13'h1ABC);
        chk("R2 act code", cmd_o, 8'h02);
        chk("R4 bank B index", bank_o, 1);
        chk("R4 row addr", addr_o, 13'h1ABC);
        chk("R4 open B", bank_open_o, 4'b0010);
        chk("R4 row stored", open_rows_o[13 +: 13], 13'h1ABC);
        act(2'b01, 13'h0123);
        chk("R4 bank C index", bank_o, 2);
        chk("R4 open B,C", bank_open_o, 4'b0110);
        chk("R2 illegal low", illegal_o, 0);
    endtask

    task automatic t_illegal();
        act(2'b10, 13'h0555);
        chk("R7 reopen flag", illegal_o, 1);
        chk("R7 reopen banks", bank_open_o, 4'b0110);
        chk("R7 row kept", open_rows_o[13 +: 13], 13'h1ABC);
        rd(2'b00, 13'h0001);
        chk("R7 closed read flag", illegal_o, 1);
        chk("R7 closed read banks", bank_open_o, 4'b0110);
        mrs(13'h0032);
        chk("R8 mrs open flag", illegal_o, 1);
        refc();
        chk("R8 ref open flag", illegal_o, 1);
        chk("R8 ref code", cmd_o, 8'h20);
        act(2'b11, 13'h0077);
        chk("R9 no lockout after bad mrs", illegal_o, 0);
        pre(2'b11, 13'h0000);
        chk("R5 single close D", bank_open_o, 4'b0110);
    endtask

    task automatic t_rw();
        rd(2'b10, 13'h0955);
        chk("R2 read code", cmd_o, 8'h04);
        chk("R6 column", addr_o, 13'h0555);
        chk("R6 no autopre", auto_pre_o, 0);
        chk("R6 bank stays", bank_open_o, 4'b0110);
        wr(2'b01, 13'h06AA);
        chk("R2 write code", cmd_o, 8'h08);
        chk("R6 column wr", addr_o, 13'h02AA);
        chk("R6 autopre", auto_pre_o, 1);
        chk("R6 autopre closes C", bank_open_o, 4'b0010);
        drive(1, 0, 1, 1, 0, 2'b10, 13'h0400);
        chk("R2 burst stop", cmd_o, 8'h80);
        chk("R6 no autopre on bst", auto_pre_o, 0);
    endtask

    task automatic t_precharge();
        pre(2'b10, 13'h0000);
        chk("R2 pre code", cmd_o, 8'h10);
        chk("R5 single close", bank_open_o, 4'b0000);
        act(2'b00, 13'h0011);
        act(2'b11, 13'h0022);
        chk("R4 open A,D", bank_open_o, 4'b1001);
        pre(2'b00, 13'h0400);
        chk("R5 all closed", bank_open_o, 4'b0000);
    endtask

    task automatic t_mrs_lock();
        mrs(13'h0032);
        chk("R2 mrs code", cmd_o, 8'h40);
        chk("R9 mrs legal", illegal_o, 0);
        chk("R6 mrs addr", addr_o, 13'h0032);
        act(2'b00, 13'h0005);
        chk("R9 lock cycle 1", illegal_o, 1);
        act(2'b00, 13'h0005);
        chk("R9 lock cycle 2", illegal_o, 1);
        chk("R9 still closed", bank_open_o, 0);
        act(2'b00, 13'h0005);
        chk("R9 accepted after", illegal_o, 0);
        chk("R9 opened", bank_open_o, 4'b0001);
        pre(2'b00, 13'h0400);
    endtask

    task automatic t_power();
        drive(0, 0, 1, 1, 1, 2'b00, 0);
        chk("R10 precharge pd", pwr_o, 1);
        drive(0, 0, 0, 1, 1, 2'b00, 13'h0009);
        chk("R10 ignored cmd", cmd_o, 8'h01);
        chk("R10 no open", bank_open_o, 0);
        drive(1, 0, 0, 1, 1, 2'b00, 13'h0009);
        chk("R10 exit on", pwr_o, 0);
        chk("R10 exit cycle nop", bank_open_o, 0);
        drive(0, 0, 0, 0, 1, 2'b00, 0);
        chk("R10 self refresh", pwr_o, 3);
        drive(1, 1, 1, 1, 1, 2'b00, 0);
        chk("R10 exit self", pwr_o, 0);
        act(2'b00, 13'h0003);
        drive(0, 0, 1, 1, 1, 2'b00, 0);
        chk("R10 active pd", pwr_o, 2);
        drive(1, 1, 1, 1, 1, 2'b00, 0);
        chk("R10 exit active pd", pwr_o, 0);
        chk("R10 bank kept", bank_open_o, 4'b0001);
        pre(2'b00, 13'h0400);
        chk("R5 closed after pd", bank_open_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        nop();
        t_cs_mask();
        t_activate();
        t_illegal();
        t_rw();
        t_precharge();
        t_mrs_lock();
        t_power();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule